// File: doc/BRIEF.md
# Conditional branch target unit

This block decides, for one instruction at a time, whether a conditional branch is taken and which address the program counter moves to next. It reads the branch-control bits of an 8-bit opcode, four status flags, the current program counter, two operand fields, an absolute address field, and the values of the two registers that the operand fields select. From these it produces a taken indication, the computed target, and the next program counter. Fetch, program counter storage and flag generation belong to the surrounding core.

The decision logic is purely combinational. A small registered helper captures the next program counter and the taken bit whenever a step strobe is high. This lets a bench or a simple sequencer walk the unit one instruction per clock without an external register.

Two opcode bits pick one of the four flags, and an invert bit turns each test into its complement, which gives eight conditions. Further bits choose between absolute and relative targeting. They also decide whether the base and the offset come from constants or from registers. A register selector of all ones stands for the program counter itself.

Top module: `branch_target_unit`

## Requirements
- R1: An opcode is a branch only when bit 1 is 1 and bit 3 is 0. For any other opcode `taken_o` is 0 and `next_pc_o` equals `pc_i` + 4, whatever the flags are.
- R2: Opcode bits 7:6 select the tested flag from `flags_i`: 00 selects bit 0 (carry), 01 selects bit 1 (zero), 10 selects bit 2 (negative), and 11 selects bit 3 (overflow). With bit 2 = 0, a branch is taken when the selected flag is 1.
- R3: Opcode bit 2 = 1 inverts the test, so the branch is taken when the selected flag is 0.
- R4: With opcode bit 0 = 0 (absolute), `target_o` is `addr_i` when bit 4 = 0. When bit 4 = 1, it is the register value selected by `opa_i`.
- R5: With opcode bit 0 = 1 (relative), `target_o` is base plus offset. The base is `opa_i` zero-extended when bit 4 = 0, and the register value selected by `opa_i` when bit 4 = 1.
- R6: The relative offset is `opb_i` when opcode bit 5 = 0 and the register value selected by `opb_i` when bit 5 = 1. It is read as an 8-bit two's-complement number, and the sum wraps modulo 2^AW.
- R7: A register selector is the low 4 bits of its operand. Selector 0xF yields `pc_i` in place of the register input; as an offset it yields the low 8 bits of `pc_i`.
- R8: When `taken_o` is 1, `next_pc_o` equals `target_o`. Otherwise it equals `pc_i` + 4, wrapping modulo 2^AW.
- R9: After reset, `pc_q_o` and `taken_q_o` are 0. On a clock edge with `step_i` = 1 they take the values of `next_pc_o` and `taken_o`, and with `step_i` = 0 they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the step register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 8 | Opcode |
| flags_i | input | 4 | Status flags: carry, zero, negative, overflow in bits 0 to 3 |
| pc_i | input | AW | Current program counter |
| opa_i | input | DW | First operand: base constant or base register selector |
| opb_i | input | DW | Second operand: offset constant or offset register selector |
| addr_i | input | AW | Absolute address field |
| rega_i | input | DW | Value of the register selected by `opa_i` |
| regb_i | input | DW | Value of the register selected by `opb_i` |
| step_i | input | 1 | Capture strobe for the step register |
| taken_o | output | 1 | Branch taken |
| target_o | output | AW | Computed branch target |
| next_pc_o | output | AW | Next program counter |
| pc_q_o | output | AW | Registered next program counter |
| taken_q_o | output | 1 | Registered taken bit |

## Verification
The assertions assume that the opcode, flags, operands and register values are stable across each rising edge, because the step register samples them there. The stimulus changes every input only on falling edges, and it holds `step_i` steady for a whole cycle. The assertions also assume that `rega_i` and `regb_i` already hold the register contents chosen by the low operand nibbles. The bench supplies these as arbitrary values, so a selector of 0xF shows whether the program counter replaces the register input. The stimulus covers all eight conditions, every base and offset source, negative offsets, and wraparound at the top of the address space.

// File: rtl/branch_target_unit.sv
module branch_target_unit #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int INSN_BYTES = 4,
  parameter int SELW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    op_i,
  input  logic [3:0]    flags_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] rega_i,
  input  logic [DW-1:0] regb_i,
  input  logic          step_i,
  output logic          taken_o,
  output logic [AW-1:0] target_o,
  output logic [AW-1:0] next_pc_o,
  output logic [AW-1:0] pc_q_o,
  output logic          taken_q_o
);
  localparam logic [SELW-1:0] PC_SEL = '1;
  localparam logic [AW-1:0]   STEP   = AW'(INSN_BYTES);

  logic          is_branch, cond;
  logic [AW-1:0] reg_a, base, off_ext, seq_pc;
  logic [DW-1:0] reg_b, off_raw;

  assign is_branch = op_i[1] & ~op_i[3];
  assign cond      = flags_i[op_i[7:6]] ^ op_i[2];
  assign taken_o   = is_branch & cond;

  assign reg_a   = (opa_i[SELW-1:0] == PC_SEL) ? pc_i : AW'(rega_i);
  assign reg_b   = (opb_i[SELW-1:0] == PC_SEL) ? DW'(pc_i) : regb_i;

  assign base    = op_i[4] ? reg_a : AW'(opa_i);
  assign off_raw = op_i[5] ? reg_b : opb_i;
  assign off_ext = AW'($signed(off_raw));

  always_comb begin
    if (op_i[0]) target_o = base + off_ext;
    else         target_o = op_i[4] ? reg_a : addr_i;
  end

  assign seq_pc    = pc_i + STEP;
  assign next_pc_o = taken_o ? target_o : seq_pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q_o    <= '0;
      taken_q_o <= 1'b0;
    end else if (step_i) begin
      pc_q_o    <= next_pc_o;
      taken_q_o <= taken_o;
    end
  end
endmodule

// File: rtl/branch_target_unit_checks.sv
module branch_target_unit_checks #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int INSN_BYTES = 4,
  parameter int SELW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    op_i,
  input logic [3:0]    flags_i,
  input logic [AW-1:0] pc_i,
  input logic [DW-1:0] opa_i,
  input logic [DW-1:0] opb_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] rega_i,
  input logic [DW-1:0] regb_i,
  input logic          step_i,
  input logic          taken_o,
  input logic [AW-1:0] target_o,
  input logic [AW-1:0] next_pc_o,
  input logic [AW-1:0] pc_q_o,
  input logic          taken_q_o
);
  localparam logic [AW-1:0] SEQ = AW'(INSN_BYTES);

  assert_nonbranch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_i[1] && !op_i[3]) |-> (!taken_o && next_pc_o == pc_i + SEQ));

  assert_carry_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i[1] && !op_i[3] && op_i[7:6] == 2'b00 && !op_i[2]) |-> (taken_o == flags_i[0]));

  assert_invert_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i[1] && !op_i[3] && op_i[2]) |-> (taken_o != flags_i[op_i[7:6]]));

  assert_absolute_const_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i[0] == 1'b0 && op_i[4] == 1'b0) |-> (target_o == addr_i));

  assert_pc_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i[0] && op_i[4] && !op_i[5] && opa_i[SELW-1:0] == '1)
      |-> (target_o == pc_i + AW'($signed(opb_i))));

  assert_next_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> (next_pc_o == target_o));

  assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (pc_q_o == $past(next_pc_o) && taken_q_o == $past(taken_o)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> ($stable(pc_q_o) && $stable(taken_q_o)));
endmodule

bind branch_target_unit branch_target_unit_checks #(
  .AW(AW), .DW(DW), .INSN_BYTES(INSN_BYTES), .SELW(SELW)
) u_checks (.*);

// File: tb/tb_branch_target_unit.sv
`timescale 1ns/1ps
module tb_branch_target_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] op_i = '0;
  logic [3:0] flags_i = '0;
  logic [7:0] pc_i = '0, opa_i = '0, opb_i = '0, addr_i = '0, rega_i = '0, regb_i = '0;
  logic       step_i = 1'b0;
  logic       taken_o, taken_q_o;
  logic [7:0] target_o, next_pc_o, pc_q_o;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    string      tag;
    logic       taken;
    logic [7:0] target;
    logic [7:0] npc;
  } exp_t;
  exp_t sb[$];
  logic [7:0] last_npc = '0;
  logic       last_taken = 1'b0;

  always #2.5 clk = ~clk;

  branch_target_unit dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .flags_i(flags_i), .pc_i(pc_i),
    .opa_i(opa_i), .opb_i(opb_i), .addr_i(addr_i), .rega_i(rega_i), .regb_i(regb_i),
    .step_i(step_i), .taken_o(taken_o), .target_o(target_o), .next_pc_o(next_pc_o),
    .pc_q_o(pc_q_o), .taken_q_o(taken_q_o)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Independent reference computed from the requirement text
  task automatic drive(string tag, logic [7:0] op, logic [3:0] fl, logic [7:0] pc,
                       logic [7:0] a, logic [7:0] b, logic [7:0] ad,
                       logic [7:0] ra, logic [7:0] rb);
    exp_t e;
    logic flag, br;
    logic [7:0] av, bv, basev, offv;
    unique case (op[7:6])
      2'b00: flag = fl[0];
      2'b01: flag = fl[1];
      2'b10: flag = fl[2];
      default: flag = fl[3];
    endcase
    br = (op[1] == 1'b1) && (op[3] == 1'b0);
    e.taken = br && (op[2] ? !flag : flag);
    av = (a[3:0] == 4'hF) ? pc : ra;
    bv = (b[3:0] == 4'hF) ? pc : rb;
    basev = op[4] ? av : a;
    offv  = op[5] ? bv : b;
    if (op[0]) e.target = 8'((int'(basev) + int'($signed(offv))) & 255);
    else       e.target = op[4] ? av : ad;
    e.npc = e.taken ? e.target : 8'(pc + 8'd4);
    e.tag = tag;
    @(negedge clk);
    op_i = op; flags_i = fl; pc_i = pc; opa_i = a; opb_i = b;
    addr_i = ad; rega_i = ra; regb_i = rb; step_i = 1'b1;
    sb.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        check({e.tag, " taken"}, {7'd0, taken_o}, {7'd0, e.taken});
        check({e.tag, " target"}, target_o, e.target);
        check({e.tag, " next_pc"}, next_pc_o, e.npc);
        check({e.tag, " R9 pc_q"}, pc_q_o, e.npc);
        check({e.tag, " R9 taken_q"}, {7'd0, taken_q_o}, {7'd0, e.taken});
        last_npc = e.npc;
        last_taken = e.taken;
      end
    end
  end

  initial begin : watchdog
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stimulus
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset pc_q", pc_q_o, 8'h00);
    check("R9 reset taken_q", {7'd0, taken_q_o}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    drive("R2 BCS set",        8'h02, 4'b0001, 8'h10, 8'h00, 8'h00, 8'h80, 8'h00, 8'h00);
    drive("R2 BCS clear",      8'h02, 4'b1110, 8'h10, 8'h00, 8'h00, 8'h80, 8'h00, 8'h00);
    drive("R3 BCC clear",      8'h06, 4'b1110, 8'h10, 8'h00, 8'h00, 8'h80, 8'h00, 8'h00);
    drive("R2 BEQ set",        8'h42, 4'b0010, 8'h20, 8'h00, 8'h00, 8'h44, 8'h00, 8'h00);
    drive("R3 BNE set",        8'h46, 4'b0010, 8'h20, 8'h00, 8'h00, 8'h44, 8'h00, 8'h00);
    drive("R2 BMI set",        8'h82, 4'b0100, 8'h30, 8'h00, 8'h00, 8'h66, 8'h00, 8'h00);
    drive("R3 BPL clear",      8'h86, 4'b1011, 8'h30, 8'h00, 8'h00, 8'h66, 8'h00, 8'h00);
    drive("R2 BVS set",        8'hC2, 4'b1000, 8'h30, 8'h00, 8'h00, 8'h70, 8'h00, 8'h00);
    drive("R3 BVC set",        8'hC6, 4'b1000, 8'h30, 8'h00, 8'h00, 8'h70, 8'h00, 8'h00);
    drive("R1 ALU op",         8'h08, 4'b1111, 8'h10, 8'h00, 8'h00, 8'h80, 8'h00, 8'h00);
    drive("R1 bit3 set",       8'h0A, 4'b1111, 8'h10, 8'h00, 8'h00, 8'h80, 8'h00, 8'h00);
    drive("R1 bit1 clear",     8'h40, 4'b1111, 8'h10, 8'h00, 8'h00, 8'h80, 8'h00, 8'h00);
    drive("R4 abs reg base",   8'h12, 4'b0001, 8'h10, 8'h03, 8'h00, 8'h80, 8'h99, 8'h00);
    drive("R7 abs pc base",    8'h12, 4'b0001, 8'h55, 8'h0F, 8'h00, 8'h80, 8'h99, 8'h00);
    drive("R6 rel const neg",  8'h03, 4'b0001, 8'h10, 8'h20, 8'hF0, 8'h00, 8'h00, 8'h00);
    drive("R6 rel wrap",       8'h03, 4'b0001, 8'h10, 8'hF0, 8'h20, 8'h00, 8'h00, 8'h00);
    drive("R5 rel reg base",   8'h13, 4'b0001, 8'h10, 8'h02, 8'h05, 8'h00, 8'h30, 8'h00);
    drive("R7 rel pc base",    8'h13, 4'b0001, 8'h40, 8'h0F, 8'h08, 8'h00, 8'h30, 8'h00);
    drive("R6 reg offset",     8'h37, 4'b0000, 8'h40, 8'h0F, 8'h01, 8'h00, 8'h00, 8'hFC);
    drive("R7 pc offset",      8'h23, 4'b0001, 8'h84, 8'h00, 8'h0F, 8'h00, 8'h00, 8'h11);
    drive("R5 const base regoff", 8'h23, 4'b0001, 8'h00, 8'h7F, 8'h02, 8'h00, 8'h00, 8'h05);
    drive("R8 seq wrap",       8'h02, 4'b0000, 8'hFE, 8'h00, 8'h00, 8'h80, 8'h00, 8'h00);
    drive("R8 untaken rel",    8'h47, 4'b0010, 8'hFD, 8'h10, 8'h10, 8'h00, 8'h00, 8'h00);

    @(negedge clk);
    step_i = 1'b0;
    op_i = 8'h02; flags_i = 4'b0001; pc_i = 8'h10; addr_i = 8'h77;
    @(posedge clk);
    #1;
    check("R9 hold pc_q", pc_q_o, last_npc);
    check("R9 hold taken_q", {7'd0, taken_q_o}, {7'd0, last_taken});
    check("R4 live next_pc", next_pc_o, 8'h77);

    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule